// File: doc/BRIEF.md
# Modulo-5 Counter with Decoded Clear

This block is a three-bit binary up-counter whose legal cycle is 0, 1, 2, 3, 4. It has no next-state rule for the wrap back to zero. It steps into code 5 and relies on a decoder to clear the register. The decoder is one two-input AND term over the bits that are set in the modulus. Codes 5 and 7 match that term. Code 6 does not match, so it is an unused code that holds its value.

In this synthesizable form the decode sits in front of the register. A matching code is replaced by zero within the same clock cycle, so the register never holds 5 or 7. A registered pulse marks each cycle in which the clear fired.

A parallel load port stands in for the arbitrary power-up state: any of the eight codes can be placed into the counter. From any of those codes the counter reaches the legal cycle within two clock edges. A terminal-count flag is high while the count is 4.

Top module: `mod5_gated_counter`

## Requirements
- R1: With `rst` high at a rising edge, the counter goes to `count`=0 with `tc`=0 and `clr_pulse`=0 after that edge, whatever `ld` and `en` are.
- R2: With `en` high, `ld` and `rst` low, and a count of 0 to 3, each rising edge raises the count by one.
- R3: From count 4, an enabled edge produces count 0 with `clr_pulse`=1. The code 5 is never visible.
- R4: Any next value whose bit 2 and bit 0 are both 1 (codes 5 and 7) is stored as 0 and sets `clr_pulse`=1. This holds for loaded values as well as counted ones.
- R5: Code 6 is unused but stable. Once loaded it is held. The next enabled edge goes through 7 and lands on 0 with `clr_pulse`=1.
- R6: Load each of the eight codes with `ld` high and the code on `ld_val`. After that edge and one enabled edge, the count is in the range 0 to 4.
- R7: With `en` low, `ld` and `rst` low, the count holds, including at codes 4 and 6, and `clr_pulse` is 0.
- R8: The clear still applies with `en` low: loading 5 or 7 gives count 0 and `clr_pulse`=1.
- R9: `tc` is 1 exactly in the cycles where `count` is 4.
- R10: Priority is `rst` over `ld` over `en`. A load takes effect whatever the level of `en`.
- R11: `clr_pulse` lasts one cycle. It is 0 after any edge whose next value did not match the clear term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| ld | input | 1 | Parallel load strobe, active high |
| ld_val | input | WIDTH | Code to place into the counter |
| count | output | WIDTH | Registered count value |
| tc | output | 1 | High while count equals MODULUS-1 |
| clr_pulse | output | 1 | High for the cycle after a decoded clear |

## Verification
The hardest situations to reach from the ports are the unused codes. In normal counting the register only ever passes 0 to 4, and code 6 cannot occur at all. The bench uses the parallel load to plant each of the eight codes, standing in for arbitrary power-up contents. For each one it checks the state after the load edge and after one enabled edge. It also holds code 6 with enable low, then releases it so the 6-to-7-to-0 path runs. A load of 5 with enable low shows that the clear does not depend on counting.

// File: rtl/mod5_pkg.sv
package mod5_pkg;

  // True when every bit set in the clear mask is also set in the value.
  function automatic logic clear_hit(input logic [31:0] value, input logic [31:0] mask);
    return (mask != 32'd0) && ((value & mask) == mask);
  endfunction

  // Width needed to hold codes 0 .. modulus.
  function automatic int unsigned code_width(input int unsigned modulus);
    int unsigned w;
    w = 1;
    while ((32'd1 << w) <= modulus) w++;
    return w;
  endfunction

endpackage

// File: rtl/mod5_step.sv
module mod5_step #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             en,
  output logic [WIDTH-1:0] raw_next
);

  always_comb begin
    if (rst)      raw_next = '0;
    else if (ld)  raw_next = ld_val;
    else if (en)  raw_next = cur + 1'b1;
    else          raw_next = cur;
  end

endmodule

// File: rtl/mod5_clear_decode.sv
module mod5_clear_decode #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned MODULUS = 5
) (
  input  logic [WIDTH-1:0] raw_next,
  output logic             clear,
  output logic [WIDTH-1:0] kept_next
);
  import mod5_pkg::*;

  localparam logic [31:0] CLR_MASK = 32'(MODULUS);

  always_comb begin
    clear     = clear_hit(32'(raw_next), CLR_MASK);
    kept_next = clear ? '0 : raw_next;
  end

endmodule

// File: rtl/mod5_gated_counter.sv
module mod5_gated_counter #(
  parameter int unsigned MODULUS = 5,
  parameter int unsigned WIDTH   = mod5_pkg::code_width(MODULUS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] count,
  output logic             tc,
  output logic             clr_pulse
);

  localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] raw_next;
  logic [WIDTH-1:0] kept_next;
  logic             clear;

  mod5_step #(.WIDTH(WIDTH)) u_step (
    .cur      (count),
    .rst      (rst),
    .ld       (ld),
    .ld_val   (ld_val),
    .en       (en),
    .raw_next (raw_next)
  );

  mod5_clear_decode #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_dec (
    .raw_next  (raw_next),
    .clear     (clear),
    .kept_next (kept_next)
  );

  always_ff @(posedge clk) begin
    count     <= kept_next;
    tc        <= (kept_next == TERM);
    clr_pulse <= clear;
  end

endmodule

// File: rtl/mod5_gated_counter_chk.sv
module mod5_gated_counter_chk #(
  parameter int unsigned MODULUS = 5,
  parameter int unsigned WIDTH   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             ld,
  input logic [WIDTH-1:0] count,
  input logic             tc,
  input logic             clr_pulse
);

  localparam logic [WIDTH-1:0] TERM = WIDTH'(MODULUS - 1);

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (!ld && en && count < TERM) |=> (count == WIDTH'($past(count) + 1'b1))); // R2

  AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!ld && en && count == TERM) |=> (count == '0 && clr_pulse)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> (count == '0)); // R4

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> ($stable(count) && !clr_pulse)); // R7

  AST_TERM_FLAG: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (tc == (count == TERM))); // R9

endmodule

bind mod5_gated_counter mod5_gated_counter_chk #(.MODULUS(MODULUS), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .ld        (ld),
  .count     (count),
  .tc        (tc),
  .clr_pulse (clr_pulse)
);

// File: tb/test_mod5_gated_counter.sv
`timescale 1ns/1ps
module test_mod5_gated_counter;

  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic ld  = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] count;
  logic tc;
  logic clr_pulse;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  mod5_gated_counter i_mod5_gated_counter (
    .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
    .count(count), .tc(tc), .clr_pulse(clr_pulse)
  );

  // Entry layout: {rst, ld, en, ld_val[2:0], exp_count[2:0], exp_tc, exp_clr}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {3'b100, 3'd0, 3'd0, 1'b0, 1'b0},  // R1 reset
    {3'b001, 3'd0, 3'd1, 1'b0, 1'b0},  // R2
    {3'b001, 3'd0, 3'd2, 1'b0, 1'b0},  // R2
    {3'b001, 3'd0, 3'd3, 1'b0, 1'b0},  // R2
    {3'b001, 3'd0, 3'd4, 1'b1, 1'b0},  // R2 R9
    {3'b001, 3'd0, 3'd0, 1'b0, 1'b1},  // R3 wrap
    {3'b000, 3'd0, 3'd0, 1'b0, 1'b0},  // R11 pulse gone
    {3'b010, 3'd6, 3'd6, 1'b0, 1'b0},  // R5 load 6
    {3'b000, 3'd0, 3'd6, 1'b0, 1'b0},  // R7 hold 6
    {3'b001, 3'd0, 3'd0, 1'b0, 1'b1},  // R5 6->7->0
    {3'b010, 3'd5, 3'd0, 1'b0, 1'b1},  // R8 load 5 en low
    {3'b011, 3'd7, 3'd0, 1'b0, 1'b1},  // R4 load 7
    {3'b010, 3'd4, 3'd4, 1'b1, 1'b0},  // R10 load en low
    {3'b000, 3'd0, 3'd4, 1'b1, 1'b0},  // R7 hold 4
    {3'b001, 3'd0, 3'd0, 1'b0, 1'b1},  // R3
    {3'b110, 3'd3, 3'd0, 1'b0, 1'b0},  // R10 reset over load
    {3'b011, 3'd2, 3'd2, 1'b0, 1'b0},  // R10 load over enable
    {3'b001, 3'd0, 3'd3, 1'b0, 1'b0},  // R2
    {3'b101, 3'd0, 3'd0, 1'b0, 1'b0}   // R1 reset over enable
  };

  task automatic check(input string req, input logic [W-1:0] ec, input logic et, input logic eclr);
    total++;
    if (count !== ec || tc !== et || clr_pulse !== eclr) begin
      bad++;
      $display("FAIL %s: count=%0d tc=%0b clr=%0b expected count=%0d tc=%0b clr=%0b",
               req, count, tc, clr_pulse, ec, et, eclr);
    end
  endtask

  task automatic step(input logic r, input logic l, input logic e, input logic [W-1:0] v);
    rst = r; ld = l; en = e; ld_val = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] settle(input logic [W-1:0] x);
    return ((x & 3'd5) == 3'd5) ? 3'd0 : x;
  endfunction

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:5]);
      check($sformatf("vector %0d (R1-R11 table)", i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R6: plant each code, then one enabled edge
    for (int c = 0; c < 8; c++) begin
      logic [W-1:0] a, b;
      a = settle(W'(c));
      b = settle(W'(a + 1));
      step(1'b0, 1'b1, 1'b0, W'(c));
      check($sformatf("R6 load %0d", c), a, a == 3'd4, (W'(c) & 3'd5) == 3'd5);
      step(1'b0, 1'b0, 1'b1, '0);
      check($sformatf("R6 recover from %0d", c), b, b == 3'd4, ((a + 1) & 3'd5) == 3'd5);
      total++;
      if (count > 3'd4) begin
        bad++;
        $display("FAIL R6: count=%0d expected <=4", count);
      end
    end

    // R2 R3 R9: one full period of five clocks from zero
    step(1'b1, 1'b0, 1'b0, '0);
    check("R1 reset before period", 3'd0, 1'b0, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      logic [W-1:0] e;
      e = W'(k % 5);
      step(1'b0, 1'b0, 1'b1, '0);
      check($sformatf("R2 period edge %0d", k), e, e == 3'd4, k == 5);
    end
    step(1'b0, 1'b0, 1'b1, '0);
    check("R11 pulse one cycle", 3'd1, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule